// File: doc/BRIEF.md
# Dual-Channel Bus-Master DMA Register Bank

This block is the host-visible register file that sits in front of the bus-master DMA engine of a two-channel disk controller. It takes byte-addressed I/O reads and writes, each with a size code, from a 16-byte window. It splits the window into one 8-byte slot per channel. Each slot holds a command byte, a status byte and a 32-bit pointer to the descriptor table in memory. The command byte drives the start and direction controls of the DMA engine, and the pointer is handed to the same engine. The engine reports back with one-cycle pulses for completion, error and interrupt.

Each channel runs a two-state machine that tracks whether a transfer is under way. It has two states. CH_IDLE means no transfer is running. CH_RUN means a transfer is running and the active status bit is set. The machine has three transitions:

- T_START moves CH_IDLE to CH_RUN when the host writes a command byte with the start bit set.
- T_STOP moves CH_RUN to CH_IDLE when the host writes a command byte with the start bit clear.
- T_DONE moves CH_RUN to CH_IDLE on a completion pulse from the engine. If a completion pulse and a start-bit write arrive in the same cycle while the machine is in CH_RUN, T_DONE takes priority.

Top module: `bmdma_regbank`

## Requirements
- R1: Channel n uses byte offsets 8n to 8n+7 of the window. Within a slot, offset 0 is the command byte, offset 2 is the status byte and offsets 4 to 7 form the pointer port. When `rd_en` is low, `rdata` is 0. Byte reads return the value zero-extended into `rdata[7:0]`.
- R2: The size codes are 00 for one byte, 01 for two bytes, 10 for four bytes, and 11, which is treated as four bytes. An access with a size other than 00 to slot offsets 0 to 3 reads all ones across the access width (0x000000FF, 0x0000FFFF or 0xFFFFFFFF) and has no effect on a write.
- R3: Slot offsets 1 and 3 read as 0xFF, and writes to them change nothing.
- R4: In the command byte, bit 0 is start and bit 3 is direction, and they drive `dma_start` and `dma_dir`. All other command bits read as 0.
- R5: The status bit 0 (active) is set by T_START and cleared by T_STOP or T_DONE. A status write leaves it unchanged, and a completion pulse leaves the command byte unchanged.
- R6: A status write loads bits 5 and 6 from the written data. Status bits 3, 4 and 7 always read 0.
- R7: An error pulse sets status bit 1 and an interrupt pulse sets status bit 2. The host clears either bit by writing a 1 to it, and a 0 leaves it unchanged. When a pulse and a clear arrive in the same cycle, the pulse wins.
- R8: The pointer port is accessed only with size 10 at slot offset 4. A write stores the data with bits 1:0 forced to 0. Other sizes read all ones across the access width and are ignored on a write.
- R9: Reset clears the command, status and pointer of every channel to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe, one cycle per access |
| rd_en | input | 1 | Host read enable; `rdata` is valid in the same cycle |
| addr | input | ADDR_W (4) | Byte offset within the window |
| acc_size | input | 2 | Access size code |
| wdata | input | 32 | Write data, with the byte value in bits 7:0 |
| rdata | output | 32 | Read data |
| hw_done | input | NUM_CH | Per-channel completion pulse from the DMA engine |
| hw_err | input | NUM_CH | Per-channel error pulse |
| hw_irq | input | NUM_CH | Per-channel interrupt pulse |
| dma_start | output | NUM_CH | Start control for each channel |
| dma_dir | output | NUM_CH | Direction control for each channel |
| tbl_ptr | output | 32*NUM_CH | Descriptor-table pointer, with channel n in bits 32n+31:32n |

## Verification
The assertions take for granted that the engine pulses are synchronous to `clk` and are sampled only at clock edges, so a one-cycle pulse has its effect at the next edge. They also assume that `addr` and `acc_size` are stable while `wr_en` is high, because the wide-write property compares the outputs across exactly one edge. The bench drives every input at the falling edge and holds each pulse or strobe for exactly one rising edge. The only overlap of a pulse with a host write comes from the one directed case that checks the priority of set over clear.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_RSVD = 2'b11
    } acc_size_e;

    typedef enum logic {
        CH_IDLE = 1'b0,
        CH_RUN  = 1'b1
    } ch_state_e;

    localparam int CMD_START_BIT = 0;
    localparam int CMD_DIR_BIT   = 3;
    localparam int STS_ACT_BIT   = 0;
    localparam int STS_ERR_BIT   = 1;
    localparam int STS_IRQ_BIT   = 2;
    localparam int STS_RW_LO     = 5;
    localparam int SLOT_BYTES    = 8;
endpackage

// File: rtl/bmdma_decode.sv
module bmdma_decode
    import bmdma_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int CH_W   = 1,
    parameter int ADDR_W = 4
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        acc_size,
    output logic [CH_W-1:0]   ch_sel,
    output logic              ch_valid,
    output logic              sel_cmd,
    output logic              sel_sts,
    output logic              sel_ptr,
    output logic              is_byte,
    output logic              is_dword,
    output logic [31:0]       width_mask
);
    logic [2:0] off;

    assign off      = addr[2:0];
    assign ch_sel   = addr[ADDR_W-1:3];
    assign ch_valid = (32'(ch_sel) < NUM_CH);
    assign sel_ptr  = off[2];
    assign sel_cmd  = !off[2] && (off[1:0] == 2'd0);
    assign sel_sts  = !off[2] && (off[1:0] == 2'd2);
    assign is_byte  = (acc_size_e'(acc_size) == SZ_BYTE);
    assign is_dword = (acc_size_e'(acc_size) == SZ_WORD) && (off[1:0] == 2'd0);

    always_comb begin
        unique case (acc_size_e'(acc_size))
            SZ_BYTE: width_mask = 32'h0000_00FF;
            SZ_HALF: width_mask = 32'h0000_FFFF;
            default: width_mask = 32'hFFFF_FFFF;
        endcase
    end
endmodule

// File: rtl/bmdma_channel.sv
module bmdma_channel
    import bmdma_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_we,
    input  logic        sts_we,
    input  logic        ptr_we,
    input  logic [31:0] wdata,
    input  logic        hw_done,
    input  logic        hw_err,
    input  logic        hw_irq,
    output logic [7:0]  cmd_q,
    output logic [7:0]  sts_q,
    output logic [31:0] ptr_q,
    output logic        start,
    output logic        dir
);
    ch_state_e  state_q, state_d;
    logic       start_q, dir_q, err_q, irq_q, active;
    logic [1:0] rw_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_IDLE;
        else        state_q <= state_d;
    end

    // transitions T_START, T_STOP, T_DONE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_IDLE: if (cmd_we && wdata[CMD_START_BIT]) state_d = CH_RUN;
            CH_RUN:  if (hw_done || (cmd_we && !wdata[CMD_START_BIT])) state_d = CH_IDLE;
            default: state_d = CH_IDLE;
        endcase
    end

    // outputs of the state machine
    always_comb begin
        unique case (state_q)
            CH_RUN:  active = 1'b1;
            default: active = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_q <= 1'b0;
            dir_q   <= 1'b0;
            rw_q    <= 2'b00;
            err_q   <= 1'b0;
            irq_q   <= 1'b0;
            ptr_q   <= '0;
        end else begin
            if (cmd_we) begin
                start_q <= wdata[CMD_START_BIT];
                dir_q   <= wdata[CMD_DIR_BIT];
            end
            if (sts_we) rw_q <= wdata[STS_RW_LO +: 2];
            if (hw_err)                            err_q <= 1'b1;
            else if (sts_we && wdata[STS_ERR_BIT]) err_q <= 1'b0;
            if (hw_irq)                            irq_q <= 1'b1;
            else if (sts_we && wdata[STS_IRQ_BIT]) irq_q <= 1'b0;
            if (ptr_we) ptr_q <= {wdata[31:2], 2'b00};
        end
    end

    assign cmd_q = {4'b0000, dir_q, 2'b00, start_q};
    assign sts_q = {1'b0, rw_q, 2'b00, irq_q, err_q, active};
    assign start = start_q;
    assign dir   = dir_q;
endmodule

// File: rtl/bmdma_regbank.sv
module bmdma_regbank
    import bmdma_pkg::*;
#(
    parameter int NUM_CH = 2,
    localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int ADDR_W = CH_W + $clog2(SLOT_BYTES)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic                rd_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [1:0]          acc_size,
    input  logic [31:0]         wdata,
    output logic [31:0]         rdata,
    input  logic [NUM_CH-1:0]   hw_done,
    input  logic [NUM_CH-1:0]   hw_err,
    input  logic [NUM_CH-1:0]   hw_irq,
    output logic [NUM_CH-1:0]   dma_start,
    output logic [NUM_CH-1:0]   dma_dir,
    output logic [NUM_CH*32-1:0] tbl_ptr
);
    logic [CH_W-1:0] ch_sel;
    logic            ch_valid, sel_cmd, sel_sts, sel_ptr, is_byte, is_dword;
    logic [31:0]     width_mask;
    logic [7:0]      cmd_arr [NUM_CH];
    logic [7:0]      sts_arr [NUM_CH];
    logic [31:0]     ptr_arr [NUM_CH];
    logic [NUM_CH*8-1:0] sts_flat;

    bmdma_decode #(.NUM_CH(NUM_CH), .CH_W(CH_W), .ADDR_W(ADDR_W)) u_dec (
        .addr(addr), .acc_size(acc_size), .ch_sel(ch_sel), .ch_valid(ch_valid),
        .sel_cmd(sel_cmd), .sel_sts(sel_sts), .sel_ptr(sel_ptr),
        .is_byte(is_byte), .is_dword(is_dword), .width_mask(width_mask)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic hit;
        assign hit = wr_en && ch_valid && (32'(ch_sel) == g);

        bmdma_channel u_ch (
            .clk(clk), .rst_n(rst_n),
            .cmd_we(hit && sel_cmd && is_byte),
            .sts_we(hit && sel_sts && is_byte),
            .ptr_we(hit && sel_ptr && is_dword),
            .wdata(wdata),
            .hw_done(hw_done[g]), .hw_err(hw_err[g]), .hw_irq(hw_irq[g]),
            .cmd_q(cmd_arr[g]), .sts_q(sts_arr[g]), .ptr_q(ptr_arr[g]),
            .start(dma_start[g]), .dir(dma_dir[g])
        );

        assign tbl_ptr[g*32 +: 32] = ptr_arr[g];
        assign sts_flat[g*8 +: 8]  = sts_arr[g];
    end

    // read mux
    always_comb begin
        logic [7:0]  byte_v;
        logic [31:0] ptr_v;
        byte_v = 8'hFF;
        ptr_v  = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (32'(ch_sel) == i) begin
                ptr_v = ptr_arr[i];
                if (sel_cmd)      byte_v = cmd_arr[i];
                else if (sel_sts) byte_v = sts_arr[i];
            end
        end
        if (!rd_en)         rdata = '0;
        else if (!ch_valid) rdata = width_mask;
        else if (sel_ptr)   rdata = is_dword ? ptr_v : width_mask;
        else                rdata = is_byte ? {24'h0, byte_v} : width_mask;
    end
endmodule

// File: rtl/bmdma_regbank_chk.sv
module bmdma_regbank_chk #(
    parameter int NUM_CH = 2,
    parameter int ADDR_W = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 wr_en,
    input logic [ADDR_W-1:0]    addr,
    input logic [1:0]           acc_size,
    input logic [NUM_CH-1:0]    hw_done,
    input logic [NUM_CH-1:0]    hw_err,
    input logic [NUM_CH-1:0]    hw_irq,
    input logic [NUM_CH-1:0]    dma_start,
    input logic [NUM_CH-1:0]    dma_dir,
    input logic [NUM_CH*32-1:0] tbl_ptr,
    input logic [NUM_CH*8-1:0]  sts_flat
);
    for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
        p_active_needs_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
            sts_flat[g*8] |-> dma_start[g]);
        p_done_ends_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (sts_flat[g*8] && hw_done[g]) |=> !sts_flat[g*8]);
        p_err_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
            hw_err[g] |=> sts_flat[g*8+1]);
        p_irq_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
            hw_irq[g] |=> sts_flat[g*8+2]);
        p_reserved_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
            !sts_flat[g*8+3] && !sts_flat[g*8+4] && !sts_flat[g*8+7]);
        p_ptr_aligned_r8: assert property (@(posedge clk) disable iff (!rst_n)
            tbl_ptr[g*32 +: 2] == 2'b00);
        p_wide_write_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && acc_size != 2'b00 && !addr[2] && 32'(addr[ADDR_W-1:3]) == g)
            |=> ($stable(dma_start[g]) && $stable(dma_dir[g])));
    end
endmodule

bind bmdma_regbank bmdma_regbank_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_bmdma_regbank.sv
module sim_bmdma_regbank;
    localparam int NUM_CH = 2;
    localparam int NV     = 22;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [1:0]  acc_size = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [1:0]  hw_done = '0, hw_err = '0, hw_irq = '0;
    logic [1:0]  dma_start, dma_dir;
    logic [63:0] tbl_ptr;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    bmdma_regbank #(.NUM_CH(NUM_CH)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .acc_size(acc_size), .wdata(wdata), .rdata(rdata), .hw_done(hw_done),
        .hw_err(hw_err), .hw_irq(hw_irq), .dma_start(dma_start),
        .dma_dir(dma_dir), .tbl_ptr(tbl_ptr)
    );

    // {req[3:0], write, addr[3:0], size[1:0], data[31:0], expect[31:0]}
    localparam logic [74:0] VEC [NV] = '{
        {4'd9, 1'b0, 4'h0, 2'b00, 32'h0,          32'h0000_0000}, // R9 cmd after reset
        {4'd4, 1'b1, 4'h0, 2'b00, 32'h0000_0009,  32'h0},
        {4'd4, 1'b0, 4'h0, 2'b00, 32'h0,          32'h0000_0009}, // R4
        {4'd5, 1'b0, 4'h2, 2'b00, 32'h0,          32'h0000_0001}, // R5 active
        {4'd4, 1'b1, 4'h0, 2'b00, 32'h0000_00FF,  32'h0},
        {4'd4, 1'b0, 4'h0, 2'b00, 32'h0,          32'h0000_0009}, // R4 other bits 0
        {4'd3, 1'b0, 4'h1, 2'b00, 32'h0,          32'h0000_00FF}, // R3
        {4'd3, 1'b0, 4'h3, 2'b00, 32'h0,          32'h0000_00FF}, // R3
        {4'd3, 1'b1, 4'h3, 2'b00, 32'h0000_0000,  32'h0},
        {4'd3, 1'b0, 4'h2, 2'b00, 32'h0,          32'h0000_0001}, // R3 no effect
        {4'd6, 1'b1, 4'h2, 2'b00, 32'h0000_00FF,  32'h0},
        {4'd6, 1'b0, 4'h2, 2'b00, 32'h0,          32'h0000_0061}, // R6
        {4'd2, 1'b1, 4'h0, 2'b01, 32'h0000_0000,  32'h0},
        {4'd2, 1'b0, 4'h0, 2'b00, 32'h0,          32'h0000_0009}, // R2 wide write
        {4'd2, 1'b0, 4'h0, 2'b01, 32'h0,          32'h0000_FFFF}, // R2
        {4'd2, 1'b0, 4'h2, 2'b10, 32'h0,          32'hFFFF_FFFF}, // R2
        {4'd8, 1'b1, 4'h4, 2'b10, 32'h1234_5677,  32'h0},
        {4'd8, 1'b0, 4'h4, 2'b10, 32'h0,          32'h1234_5674}, // R8
        {4'd8, 1'b0, 4'h4, 2'b00, 32'h0,          32'h0000_00FF}, // R8
        {4'd1, 1'b1, 4'hC, 2'b10, 32'hDEAD_BEEF,  32'h0},
        {4'd1, 1'b0, 4'hC, 2'b10, 32'h0,          32'hDEAD_BEEC}, // R1 channel 1 slot
        {4'd1, 1'b0, 4'h8, 2'b00, 32'h0,          32'h0000_0000}  // R1 channel 1 cmd apart
    };

    task automatic chk(input int req, input logic [31:0] act, input logic [31:0] exp,
                       input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL R%0d %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [1:0] s, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; acc_size = s; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int req, input logic [3:0] a, input logic [1:0] s,
                      input logic [31:0] exp);
        @(negedge clk);
        rd_en = 1'b1; addr = a; acc_size = s;
        #2;
        chk(req, rdata, exp, "read");
        rd_en = 1'b0;
    endtask

    initial begin
        #(20 * 100000);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R9 reset state at the ports, R1 idle read data
        chk(9, {30'b0, dma_start}, 32'h0, "start after reset");
        chk(9, tbl_ptr[31:0], 32'h0, "ptr0 after reset");
        chk(1, rdata, 32'h0, "rdata with rd_en low");

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][70]) wr(VEC[i][69:66], VEC[i][65:64], VEC[i][63:32]);
            else            rd(int'(VEC[i][74:71]), VEC[i][69:66], VEC[i][65:64], VEC[i][31:0]);
        end

        // R4 direction output
        chk(4, {31'b0, dma_dir[0]}, 32'h1, "dir port ch0");
        // R7 sticky bits on channel 1
        @(negedge clk); hw_err[1] = 1'b1; @(negedge clk); hw_err[1] = 1'b0;
        rd(7, 4'hA, 2'b00, 32'h02);
        @(negedge clk); hw_irq[1] = 1'b1; @(negedge clk); hw_irq[1] = 1'b0;
        rd(7, 4'hA, 2'b00, 32'h06);
        wr(4'hA, 2'b00, 32'h02);
        rd(7, 4'hA, 2'b00, 32'h04);
        // R7 set beats clear in the same cycle
        @(negedge clk);
        hw_irq[1] = 1'b1; wr_en = 1'b1; addr = 4'hA; acc_size = 2'b00; wdata = 32'h04;
        @(negedge clk);
        hw_irq[1] = 1'b0; wr_en = 1'b0;
        rd(7, 4'hA, 2'b00, 32'h04);
        wr(4'hA, 2'b00, 32'h04);
        rd(7, 4'hA, 2'b00, 32'h00);

        // R5 done pulse ends the run, command retained, restart
        wr(4'h8, 2'b00, 32'h01);
        chk(5, {31'b0, dma_start[1]}, 32'h1, "start port ch1");
        rd(5, 4'hA, 2'b00, 32'h01);
        @(negedge clk); hw_done[1] = 1'b1; @(negedge clk); hw_done[1] = 1'b0;
        rd(5, 4'hA, 2'b00, 32'h00);
        rd(5, 4'h8, 2'b00, 32'h01);
        wr(4'h8, 2'b00, 32'h01);
        rd(5, 4'hA, 2'b00, 32'h01);

        // R2 reserved size code, R8 narrow pointer write ignored
        rd(2, 4'h4, 2'b11, 32'hFFFF_FFFF);
        wr(4'h4, 2'b00, 32'h0000_00AA);
        rd(8, 4'h4, 2'b10, 32'h1234_5674);
        chk(8, tbl_ptr[63:32], 32'hDEAD_BEEC, "ptr1 port");

        // R9 reset in the middle of a run
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        chk(9, {30'b0, dma_start}, 32'h0, "start after mid reset");
        chk(9, tbl_ptr[63:32], 32'h0, "ptr1 after mid reset");
        rd(9, 4'hA, 2'b00, 32'h00);
        rd(9, 4'h2, 2'b00, 32'h00);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule